// File: doc/BRIEF.md
# Legacy System Control Port Unit

This block is a small set of I/O-mapped control ports for a legacy PC-style platform. It sits on a byte-wide I/O bus that carries an address, write data, a write strobe and a read strobe. It provides three ports:

- **Fast gate-and-reset control byte.** One bit of this byte drives the A20 address gate level. Writing another bit as one issues a single-cycle system reset request.
- **Floating-point error latch.** The CPU raises the latch through a set input, and a write to a clear port lowers it.
- **Write-only sink port.** Writes to it are accepted and do nothing.

Software writes and reads the control byte through its port. Reads of any address the block does not serve return all ones and do not assert the read-valid output.

Two resets are used. The power-on reset `por` zeroes everything. The device reset `rst` clears only the reset-request bit of the control byte. The gate level and the other stored bits survive it, so the system reset that this block requests does not drop the A20 setting the software chose.

Top module: `sysctl_port_unit`

## Requirements
- R1: After power-on reset, the control byte reads as 0x00, and `a20_gate`, `sys_reset_req` and `ferr_irq` are all low.
- R2: A write to address 0x92 stores all eight data bits. A read of 0x92 returns the stored byte on `io_rdata` with `io_rvalid` high in the cycle after the read strobe.
- R3: `a20_gate` equals bit 1 of the stored control byte and follows a write from the cycle after the write strobe.
- R4: A write to 0x92 with data bit 0 set drives `sys_reset_req` high for exactly the cycle after the write strobe.
- R5: `sys_reset_req` stays low in every cycle not preceded by such a write, even while bit 0 of the stored byte remains one.
- R6: Device reset `rst` clears bit 0 of the control byte and leaves bits 7..1 (and therefore `a20_gate`) unchanged.
- R7: A cycle with `ferr_set` high raises `ferr_irq` from the next cycle. It stays high until a write of any data to address 0xF0, which lowers it a cycle later. When the set and the clear come in the same cycle, the set wins. Power-on or device reset also clears it.
- R8: Writes to address 0x80 of any value change no output and no stored state.
- R9: A read of any address other than 0x92, including 0x80 and 0xF0, returns 0xFF with `io_rvalid` low one cycle later. Whenever `io_rvalid` is low, `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | Device reset, synchronous, active high, clears control bit 0, request and error latch |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | High for one cycle when `io_rdata` carries a decoded read |
| ferr_set | input | 1 | Floating-point error event from the CPU |
| a20_gate | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| ferr_irq | output | 1 | Floating-point error interrupt level |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data path and the port addresses 0x92, 0xF0 and 0x80. With these values, full addresses such as 0x1234 fall outside the decode and exercise the all-ones read path. The control byte is wide enough to carry patterns where the gate and reset bits take every combination while the upper bits vary, so the bench can see that a device reset touches only bit 0. The 16-bit address also lets the bench confirm that the two write-only ports give nothing back on a read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Bit positions inside the control byte; the platform decodes these.
    localparam int RST_BIT = 0;
    localparam int GATE_BIT = 1;

    // Index of each port in the decoder's address list.
    localparam int PORT_CTRL  = 0;
    localparam int PORT_FCLR  = 1;
    localparam int PORT_SINK  = 2;
    localparam int NUM_PORTS  = 3;

    typedef struct packed {
        logic sink;
        logic fclr;
        logic ctrl;
    } port_hit_t;

    typedef struct packed {
        logic valid;
        logic [7:0] data;
    } rd_resp_t;

    // Value the control byte keeps across a device reset.
    function automatic logic [7:0] keep_on_devrst(input logic [7:0] cur);
        logic [7:0] v;
        v = cur;
        v[RST_BIT] = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int ADDR_W = 16,
    parameter int NPORT = 3,
    parameter logic [NPORT*ADDR_W-1:0] ADDR_LIST = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORT-1:0]  hit
);
    for (genvar i = 0; i < NPORT; i++) begin : g_cmp
        assign hit[i] = (addr == ADDR_LIST[i*ADDR_W +: ADDR_W]);
    end
endmodule

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              a20_gate,
    output logic              reset_req
);
    logic [DATA_W-1:0] ctrl_r;
    logic              req_r;

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_r <= '0;
            req_r  <= 1'b0;
        end else if (rst) begin
            ctrl_r <= keep_on_devrst(ctrl_r);
            req_r  <= 1'b0;
        end else begin
            if (wr_en) ctrl_r <= wdata;
            req_r <= wr_en & wdata[RST_BIT];
        end
    end

    assign ctrl_q    = ctrl_r;
    assign a20_gate  = ctrl_r[GATE_BIT];
    assign reset_req = req_r;

    // R4: a write with the reset bit set requests reset on the next cycle
    p_req_after_write_r4: assert property (@(posedge clk) disable iff (por || rst)
        (wr_en && wdata[RST_BIT]) |=> reset_req);

    // R5: no request without a fresh write carrying the reset bit
    p_req_no_retrigger_r5: assert property (@(posedge clk) disable iff (por || rst)
        !(wr_en && wdata[RST_BIT]) |=> !reset_req);

    // R3: the gate follows the written bit
    p_gate_follows_r3: assert property (@(posedge clk) disable iff (por || rst)
        wr_en |=> (a20_gate == $past(wdata[GATE_BIT])));

    // R6: device reset keeps all bits above the reset bit
    p_devrst_keeps_r6: assert property (@(posedge clk) disable iff (por)
        rst |=> (ctrl_q[DATA_W-1:1] == $past(ctrl_q[DATA_W-1:1]) && !ctrl_q[RST_BIT]));
endmodule

// File: rtl/sysctl_err_latch.sv
module sysctl_err_latch (
    input  logic clk,
    input  logic por,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_wr,
    output logic irq
);
    logic irq_r;

    always_ff @(posedge clk) begin
        if (por || rst)      irq_r <= 1'b0;
        else if (set_evt)    irq_r <= 1'b1;
        else if (clr_wr)     irq_r <= 1'b0;
    end

    assign irq = irq_r;

    // R7: an event raises the interrupt, set wins over clear
    p_err_set_r7: assert property (@(posedge clk) disable iff (por || rst)
        set_evt |=> irq);

    // R7: the interrupt holds until a clear write
    p_err_hold_r7: assert property (@(posedge clk) disable iff (por || rst)
        (irq && !clr_wr) |=> irq);
endmodule

// File: rtl/sysctl_port_unit.sv
module sysctl_port_unit
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0092,
    parameter logic [ADDR_W-1:0] FCLR_ADDR = 16'h00F0,
    parameter logic [ADDR_W-1:0] SINK_ADDR = 16'h0080
) (
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rvalid,
    input  logic              ferr_set,
    output logic              a20_gate,
    output logic              sys_reset_req,
    output logic              ferr_irq
);
    localparam logic [NUM_PORTS*ADDR_W-1:0] ADDR_LIST = {SINK_ADDR, FCLR_ADDR, CTRL_ADDR};
    localparam logic [DATA_W-1:0] IDLE_DATA = '1;

    logic [NUM_PORTS-1:0] hit_vec;
    port_hit_t            hit;
    logic [DATA_W-1:0]    ctrl_q;
    logic [DATA_W-1:0]    rdata_r;
    logic                 rvalid_r;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .NPORT(NUM_PORTS), .ADDR_LIST(ADDR_LIST)
    ) u_dec (
        .addr(io_addr), .hit(hit_vec)
    );

    assign hit.ctrl = hit_vec[PORT_CTRL];
    assign hit.fclr = hit_vec[PORT_FCLR];
    assign hit.sink = hit_vec[PORT_SINK];

    sysctl_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .por(por), .rst(rst),
        .wr_en(io_wr & hit.ctrl), .wdata(io_wdata),
        .ctrl_q(ctrl_q), .a20_gate(a20_gate), .reset_req(sys_reset_req)
    );

    sysctl_err_latch u_err (
        .clk(clk), .por(por), .rst(rst),
        .set_evt(ferr_set), .clr_wr(io_wr & hit.fclr), .irq(ferr_irq)
    );

    // Only the control byte is readable; the sink port is write-only.
    always_ff @(posedge clk) begin
        if (por || rst) begin
            rvalid_r <= 1'b0;
            rdata_r  <= IDLE_DATA;
        end else if (io_rd && hit.ctrl) begin
            rvalid_r <= 1'b1;
            rdata_r  <= ctrl_q;
        end else begin
            rvalid_r <= 1'b0;
            rdata_r  <= IDLE_DATA;
        end
    end

    assign io_rdata  = rdata_r;
    assign io_rvalid = rvalid_r;

    // R9: reads outside the control port give all ones and no valid
    p_undecoded_read_r9: assert property (@(posedge clk) disable iff (por || rst)
        (io_rd && !hit.ctrl) |=> (!io_rvalid && io_rdata == IDLE_DATA));

    // R8: a sink write leaves the control byte untouched
    p_sink_no_effect_r8: assert property (@(posedge clk) disable iff (por || rst)
        (io_wr && hit.sink) |=> $stable(ctrl_q));

    // R2: a control read returns the byte held at the strobe
    p_ctrl_readback_r2: assert property (@(posedge clk) disable iff (por || rst)
        (io_rd && hit.ctrl) |=> (io_rvalid && io_rdata == $past(ctrl_q)));
endmodule

// File: tb/sim_sysctl_port_unit.sv
`timescale 1ns/1ps
module sim_sysctl_port_unit;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        ferr_set = 1'b0;
    logic        a20_gate;
    logic        sys_reset_req;
    logic        ferr_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysctl_port_unit u0 (
        .clk(clk), .por(por), .rst(rst),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid), .ferr_set(ferr_set),
        .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .ferr_irq(ferr_irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge; results of the following rising edge are
    // visible at the next falling edge.
    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        d = io_rdata; v = io_rvalid;
        io_rd = 1'b0;
    endtask

    task automatic t_power_on;
        logic [7:0] d; logic v;
        chk("R1", "a20 after por", {7'b0, a20_gate}, 8'h00);
        chk("R1", "req after por", {7'b0, sys_reset_req}, 8'h00);
        chk("R1", "ferr after por", {7'b0, ferr_irq}, 8'h00);
        io_read(16'h0092, d, v);
        chk("R1", "ctrl after por", d, 8'h00);
        chk("R2", "rvalid on ctrl read", {7'b0, v}, 8'h01);
    endtask

    task automatic t_write_read;
        logic [7:0] d; logic v;
        io_write(16'h0092, 8'hA6);
        chk("R3", "a20 set by bit1", {7'b0, a20_gate}, 8'h01);
        chk("R5", "no req when bit0 clear", {7'b0, sys_reset_req}, 8'h00);
        io_read(16'h0092, d, v);
        chk("R2", "readback A6", d, 8'hA6);
        io_write(16'h0092, 8'h5C);
        chk("R3", "a20 cleared by bit1", {7'b0, a20_gate}, 8'h00);
        io_read(16'h0092, d, v);
        chk("R2", "readback 5C", d, 8'h5C);
    endtask

    task automatic t_reset_pulse;
        logic [7:0] d; logic v;
        io_write(16'h0092, 8'h03);
        chk("R4", "req pulse", {7'b0, sys_reset_req}, 8'h01);
        chk("R3", "a20 with reset write", {7'b0, a20_gate}, 8'h01);
        @(negedge clk);
        chk("R4", "req one cycle only", {7'b0, sys_reset_req}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R5", "req no retrigger", {7'b0, sys_reset_req}, 8'h00);
        io_read(16'h0092, d, v);
        chk("R2", "readback 03", d, 8'h03);
        chk("R5", "req stays low after read", {7'b0, sys_reset_req}, 8'h00);
    endtask

    task automatic t_device_reset;
        logic [7:0] d; logic v;
        io_write(16'h0092, 8'hC3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R6", "a20 kept over rst", {7'b0, a20_gate}, 8'h01);
        chk("R6", "req low after rst", {7'b0, sys_reset_req}, 8'h00);
        io_read(16'h0092, d, v);
        chk("R6", "only bit0 cleared", d, 8'hC2);
    endtask

    task automatic t_sink_port;
        logic [7:0] d; logic v;
        io_write(16'h0080, 8'hFF);
        chk("R8", "sink write no req", {7'b0, sys_reset_req}, 8'h00);
        chk("R8", "sink write a20 kept", {7'b0, a20_gate}, 8'h01);
        io_write(16'h0080, 8'h00);
        chk("R8", "sink zero write a20 kept", {7'b0, a20_gate}, 8'h01);
        io_read(16'h0092, d, v);
        chk("R8", "ctrl unchanged by sink", d, 8'hC2);
        io_read(16'h0080, d, v);
        chk("R9", "sink read data", d, 8'hFF);
        chk("R9", "sink read valid", {7'b0, v}, 8'h00);
    endtask

    task automatic t_err_latch;
        logic [7:0] d; logic v;
        @(negedge clk);
        ferr_set = 1'b1;
        @(negedge clk);
        ferr_set = 1'b0;
        chk("R7", "ferr raised", {7'b0, ferr_irq}, 8'h01);
        io_write(16'h0080, 8'h55);
        chk("R8", "sink write keeps ferr", {7'b0, ferr_irq}, 8'h01);
        io_read(16'h00F0, d, v);
        chk("R9", "clear port read data", d, 8'hFF);
        chk("R9", "clear port read valid", {7'b0, v}, 8'h00);
        chk("R7", "read does not clear ferr", {7'b0, ferr_irq}, 8'h01);
        io_write(16'h00F0, 8'h00);
        chk("R7", "write F0 clears ferr", {7'b0, ferr_irq}, 8'h00);
        @(negedge clk);
        io_addr = 16'h00F0; io_wdata = 8'h7E; io_wr = 1'b1; ferr_set = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; ferr_set = 1'b0;
        chk("R7", "set wins over clear", {7'b0, ferr_irq}, 8'h01);
        io_write(16'h00F0, 8'hFF);
        chk("R7", "clear with any data", {7'b0, ferr_irq}, 8'h00);
    endtask

    task automatic t_undecoded;
        logic [7:0] d; logic v;
        io_read(16'h1234, d, v);
        chk("R9", "undecoded read data", d, 8'hFF);
        chk("R9", "undecoded read valid", {7'b0, v}, 8'h00);
        @(negedge clk);
        chk("R9", "idle rdata", io_rdata, 8'hFF);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                por = 1'b0;
                @(negedge clk);
                t_power_on();
                t_write_read();
                t_reset_pulse();
                t_device_reset();
                t_sink_port();
                t_err_latch();
                t_undecoded();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule